// File: doc/BRIEF.md
# Blocking MSI Data Cache

This block is a private first-level data cache for one core in a multi-core system. It holds sixteen direct-mapped lines and keeps them coherent with the other private caches under the MSI protocol. It serves one load or store at a time. A load that finds its line readable, or a store that finds its line writable, completes locally. Any other access starts a miss sequence, which is resolved entirely by messages exchanged with a parent coherence controller. The parent can also ask the cache at any time to drop a line to a lower state. The cache answers such a request with the line's data when the line holds the only up-to-date copy.

On the core side there is a request port, which carries the operation, byte address, store data and a 32-bit request ID, and a response port that returns load data together with that ID. On the parent side there is one outgoing message channel and one incoming message channel, each with a valid/ready handshake. The outgoing channel carries upgrade requests and downgrade responses. The incoming channel carries upgrade responses and downgrade requests. A flag on each message marks it as a response or a request. Only loads and stores are legal operations. Any other operation code is accepted and flagged as an error, and it produces no response.

Top module: `msi_dcache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, and no response, message or error is pending. The first load therefore misses.
- R2: Address bits [3:2] select the word in a 4-word line, bits [7:4] select one of 16 lines, and bits [31:8] form the tag. State codes are I=0, S=1 and M=2, ordered M > S > I. Operation code 0 is a load and 1 is a store.
- R3: A load whose line has a matching tag and state S or M returns the addressed word and its request ID on `rsp_valid`, and sends no parent message.
- R4: A store hits only in state M. A store to a line in S sends an upgrade request for state M.
- R5: A miss sends an upgrade request with the child ID, the line-aligned address (low 4 bits zero) and the wanted state: S for a load, M for a store. Once the upgrade response arrives, the access is replayed and completes.
- R6: When the indexed line is valid with a different tag, the cache first sends a downgrade response to I for the old address, with data exactly when the line was M. Only after that does it send the upgrade request.
- R7: A downgrade request for a present line held above the target state is answered with a downgrade response that carries the target state, and carries the line data exactly when the line was M. The line is then held at the target state.
- R8: A downgrade request whose line is absent, or already at or below the target state, is consumed with no message, and the line's state and data are left unchanged.
- R9: An operation code other than 0 or 1 raises `op_err` for one cycle, the cycle after acceptance. It gives no response and sends no message.
- R10: While a downgrade request waits at an idle cache, `req_ready` is low, so the parent's request takes precedence over a core request in the same cycle.
- R11: A downgrade request is serviced while the cache waits for an upgrade response.
- R12: An upgrade response with data installs the line. One without data keeps the existing line contents and only raises the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Core request accepted this cycle |
| req_op | input | 3 | Operation code (0 load, 1 store) |
| req_addr | input | 32 | Byte address |
| req_data | input | 32 | Store data |
| req_rid | input | 32 | Request ID |
| rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| rsp_data | output | 32 | Load data |
| rsp_rid | output | 32 | ID of the completed load |
| op_err | output | 1 | Illegal operation pulse |
| out_valid | output | 1 | Message to parent present |
| out_ready | input | 1 | Parent accepts message |
| out_is_resp | output | 1 | 1 downgrade response, 0 upgrade request |
| out_child | output | 2 | This cache's child ID |
| out_addr | output | 32 | Line-aligned address |
| out_state | output | 2 | Wanted or resulting MSI state |
| out_has_data | output | 1 | Message carries line data |
| out_data | output | 128 | Line data |
| in_valid | input | 1 | Message from parent present |
| in_ready | output | 1 | Message consumed this cycle |
| in_is_resp | input | 1 | 1 upgrade response, 0 downgrade request |
| in_addr | input | 32 | Line address |
| in_state | input | 2 | Granted or target MSI state |
| in_has_data | input | 1 | Message carries line data |
| in_data | input | 128 | Line data |

## Verification
A parent downgrade request can collide with the core's own traffic in two ways. It can arrive in the same cycle as a new core request at an idle cache, or it can arrive while the cache is waiting for the response to its own upgrade. The bench presents a downgrade request and a load in the same cycle. It checks that the load is held off while the downgrade is consumed, and that the load then completes with the correct data. In the second case, the bench withholds an upgrade response and sends a downgrade request for a different line. It checks that the downgrade response appears first, and that the later miss on that line sends an upgrade request with no voluntary eviction, which proves that the line really dropped to I.

// File: rtl/msi_dcache.sv
module msi_dcache #(
  parameter int CHILD_ID   = 0,
  parameter int CID_W      = 2,
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int ROWS       = 16,
  parameter int OP_W       = 3,
  parameter int LINE_W     = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_data,
  input  logic [31:0]       req_rid,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic [31:0]       rsp_rid,
  output logic              op_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_resp,
  output logic [CID_W-1:0]  out_child,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_state,
  output logic              out_has_data,
  output logic [LINE_W-1:0] out_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_resp,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_state,
  input  logic              in_has_data,
  input  logic [LINE_W-1:0] in_data
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(ROWS);
  localparam int LO_W   = BYTE_W + OFF_W;
  localparam int TAG_LO = LO_W + IDX_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;

  typedef enum logic [2:0] {F_IDLE, F_LOOK, F_WB, F_UPREQ, F_WAIT} fsm_t;
  fsm_t fsm;

  logic [1:0]        line_st  [ROWS];
  logic [TAG_W-1:0]  line_tag [ROWS];
  logic [LINE_W-1:0] line_dat [ROWS];

  logic              is_st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [31:0]       rid_q;

  wire [IDX_W-1:0] r_idx  = addr_q[TAG_LO-1:LO_W];
  wire [TAG_W-1:0] r_tag  = addr_q[ADDR_W-1:TAG_LO];
  wire [OFF_W-1:0] r_word = addr_q[LO_W-1:BYTE_W];
  wire [1:0]       r_st   = line_st[r_idx];
  wire             r_tmatch = line_tag[r_idx] == r_tag;
  wire             hit    = r_tmatch && (is_st_q ? (r_st == ST_M) : (r_st != ST_I));
  wire             victim = (r_st != ST_I) && !r_tmatch;

  wire [IDX_W-1:0] d_idx  = in_addr[TAG_LO-1:LO_W];
  wire [1:0]       d_cur  = (line_tag[d_idx] == in_addr[ADDR_W-1:TAG_LO]) ? line_st[d_idx] : ST_I;
  wire             d_need = d_cur > in_state;
  wire             d_take = in_valid && !in_is_resp && (fsm == F_IDLE || fsm == F_WAIT);
  wire             u_take = in_valid && in_is_resp && fsm == F_WAIT;
  wire             d_send = d_take && d_need;

  assign in_ready  = (d_take && (!d_need || out_ready)) || u_take;
  assign req_ready = fsm == F_IDLE && !(in_valid && !in_is_resp);
  assign out_child = CID_W'(CHILD_ID);
  assign out_valid = d_send || fsm == F_WB || fsm == F_UPREQ;

  always_comb begin
    out_is_resp  = 1'b1;
    out_addr     = {in_addr[ADDR_W-1:LO_W], {LO_W{1'b0}}};
    out_state    = in_state;
    out_has_data = d_cur == ST_M;
    out_data     = line_dat[d_idx];
    if (fsm == F_WB) begin
      out_addr     = {line_tag[r_idx], r_idx, {LO_W{1'b0}}};
      out_state    = ST_I;
      out_has_data = r_st == ST_M;
      out_data     = line_dat[r_idx];
    end else if (fsm == F_UPREQ) begin
      out_is_resp  = 1'b0;
      out_addr     = {addr_q[ADDR_W-1:LO_W], {LO_W{1'b0}}};
      out_state    = is_st_q ? ST_M : ST_S;
      out_has_data = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm       <= F_IDLE;
      rsp_valid <= 1'b0;
      op_err    <= 1'b0;
      for (int i = 0; i < ROWS; i++) line_st[i] <= ST_I;
    end else begin
      rsp_valid <= 1'b0;
      op_err    <= 1'b0;
      if (d_send && out_ready) line_st[d_idx] <= in_state;
      case (fsm)
        F_IDLE: if (req_valid && req_ready) begin
          if (req_op > OP_W'(1)) op_err <= 1'b1;
          else fsm <= F_LOOK;
        end
        F_LOOK: if (hit) begin
          fsm <= F_IDLE;
          if (is_st_q) line_dat[r_idx][r_word*WORD_W +: WORD_W] <= wdata_q;
          else begin
            rsp_valid <= 1'b1;
            rsp_data  <= line_dat[r_idx][r_word*WORD_W +: WORD_W];
            rsp_rid   <= rid_q;
          end
        end else fsm <= victim ? F_WB : F_UPREQ;
        F_WB: if (out_ready) begin
          line_st[r_idx] <= ST_I;
          fsm <= F_UPREQ;
        end
        F_UPREQ: if (out_ready) fsm <= F_WAIT;
        F_WAIT: if (u_take) begin
          line_st[r_idx]  <= in_state;
          line_tag[r_idx] <= r_tag;
          if (in_has_data) line_dat[r_idx] <= in_data;
          fsm <= F_LOOK;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (fsm == F_IDLE && req_valid && req_ready) begin
      is_st_q <= req_op == OP_W'(1);
      addr_q  <= req_addr;
      wdata_q <= req_data;
      rid_q   <= req_rid;
    end

  assert_bad_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op > OP_W'(1)) |=> (op_err && !rsp_valid));
  assert_upreq_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_resp) |-> (out_state != ST_I));
  assert_msg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_is_resp)));
  assert_parent_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_is_resp) |-> !req_ready);
  assert_one_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/msi_dcache_tb.sv
`timescale 1ns/1ps
module msi_dcache_tb_top;
  localparam int CID = 1;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, out_ready = 0, in_valid = 0, in_is_resp = 0, in_has_data = 0;
  logic [2:0] req_op = 0;
  logic [31:0] req_addr = 0, req_data = 0, req_rid = 0, in_addr = 0;
  logic [1:0] in_state = 0;
  logic [127:0] in_data = 0;
  logic req_ready, rsp_valid, op_err, out_valid, out_is_resp, out_has_data, in_ready;
  logic [31:0] rsp_data, rsp_rid, out_addr;
  logic [1:0] out_child, out_state;
  logic [127:0] out_data;
  int n_run = 0, n_fail = 0;
  logic [127:0] a_line;

  always #2.5 clk = ~clk;

  msi_dcache #(.CHILD_ID(CID)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  function automatic logic [127:0] line_of(input logic [31:0] s);
    return {s + 32'd3, s + 32'd2, s + 32'd1, s};
  endfunction

  task automatic core_req(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d, input logic [31:0] rid);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d; req_rid = rid;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_rsp(input logic [31:0] rid, input logic [31:0] exp, input string tag);
    int k = 0; bit seen = 0, msg = 0;
    while (k < 20 && !seen) begin
      @(negedge clk);
      if (out_valid) msg = 1;
      if (rsp_valid) begin
        seen = 1;
        chk(rsp_data == exp && rsp_rid == rid, tag, {rsp_rid, rsp_data}, {rid, exp});
      end
      k++;
    end
    if (!seen) chk(0, {tag, " no response"}, 0, 1);
    chk(!msg, {tag, " unexpected parent message"}, msg, 0);
  endtask

  task automatic expect_out(input bit is_resp, input logic [31:0] a, input logic [1:0] st,
                            input bit hd, input logic [127:0] d, input string tag);
    int k = 0;
    @(negedge clk);
    while (!out_valid && k < 20) begin @(negedge clk); k++; end
    chk(out_valid && out_is_resp == is_resp && out_addr == a && out_state == st &&
        out_child == 2'(CID) && out_has_data == hd && (!hd || out_data == d), tag,
        {out_valid, out_is_resp, out_has_data, out_state, out_addr},
        {1'b1, is_resp, hd, st, a});
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic send_up(input logic [1:0] st, input bit hd, input logic [127:0] d, input string tag);
    in_valid = 1; in_is_resp = 1; in_state = st; in_has_data = hd; in_data = d;
    #1;
    chk(in_ready, tag, in_ready, 1);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic downgrade(input logic [31:0] a, input logic [1:0] tgt, input bit exp_msg,
                           input bit hd, input logic [127:0] d, input string tag);
    @(negedge clk);
    in_valid = 1; in_is_resp = 0; in_addr = a; in_state = tgt; out_ready = 1;
    #1;
    chk(in_ready && out_valid == exp_msg, {tag, " handshake"}, {in_ready, out_valid}, {1'b1, exp_msg});
    if (exp_msg)
      chk(out_is_resp && out_state == tgt && out_has_data == hd && (!hd || out_data == d) &&
          out_addr == {a[31:4], 4'h0}, tag, {out_has_data, out_state, out_addr}, {hd, tgt, a});
    @(negedge clk);
    in_valid = 0; out_ready = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(req_ready && !out_valid && !rsp_valid && !op_err, "R1 reset outputs",
        {req_ready, out_valid, rsp_valid, op_err}, 4'b1000);
  endtask

  task automatic t_load_miss;
    core_req(0, 32'h1014, 0, 1);
    expect_out(0, 32'h1010, 1, 0, 0, "R1 R5 R2 load miss upgrade to S");
    in_addr = 32'h1010;
    send_up(1, 1, line_of(32'h1000), "R12 response accepted");
    wait_rsp(1, 32'h1001, "R5 R12 replayed load data");
    a_line = line_of(32'h1000);
  endtask

  task automatic t_load_hit;
    core_req(0, 32'h1018, 0, 2);
    wait_rsp(2, 32'h1002, "R3 load hit in S");
  endtask

  task automatic t_store_upgrade;
    core_req(1, 32'h1014, 32'hDEADBEEF, 3);
    expect_out(0, 32'h1010, 2, 0, 0, "R4 store in S asks for M");
    send_up(2, 0, 0, "R12 dataless grant");
    a_line[63:32] = 32'hDEADBEEF;
    core_req(0, 32'h1014, 0, 4);
    wait_rsp(4, 32'hDEADBEEF, "R12 line kept and store merged");
    core_req(0, 32'h1010, 0, 5);
    wait_rsp(5, 32'h1000, "R12 untouched word kept");
  endtask

  task automatic t_downgrade_m;
    downgrade(32'h1010, 1, 1, 1, a_line, "R7 M to S with data");
    core_req(1, 32'h1014, 32'hCAFE0001, 6);
    expect_out(0, 32'h1010, 2, 0, 0, "R7 line now S so store misses");
    send_up(2, 0, 0, "R12 grant");
    a_line[63:32] = 32'hCAFE0001;
  endtask

  task automatic t_downgrade_ignored;
    downgrade(32'h2020, 0, 0, 0, 0, "R8 absent line ignored");
    downgrade(32'h1010, 2, 0, 0, 0, "R8 already at target ignored");
    downgrade(32'h7010, 0, 0, 0, 0, "R8 tag mismatch ignored");
    core_req(1, 32'h1018, 32'h0BAD0002, 7);
    core_req(0, 32'h1018, 0, 8);
    wait_rsp(8, 32'h0BAD0002, "R8 line still M, store hit");
    a_line[95:64] = 32'h0BAD0002;
  endtask

  task automatic t_priority;
    @(negedge clk);
    in_valid = 1; in_is_resp = 0; in_addr = 32'h2020; in_state = 0;
    req_valid = 1; req_op = 0; req_addr = 32'h1014; req_rid = 9;
    #1;
    chk(!req_ready && in_ready, "R10 parent request first", {req_ready, in_ready}, 2'b01);
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(req_ready, "R10 core request resumes", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    wait_rsp(9, 32'hCAFE0001, "R10 R3 held load completes");
  endtask

  task automatic t_bad_op;
    core_req(3, 32'h1014, 0, 10);
    #1;
    chk(op_err, "R9 error pulse", op_err, 1);
    @(negedge clk);
    chk(!op_err && !rsp_valid && !out_valid, "R9 pulse ends, no response",
        {op_err, rsp_valid, out_valid}, 0);
    @(negedge clk);
    chk(!rsp_valid && !out_valid && req_ready, "R9 still idle", {rsp_valid, out_valid, req_ready}, 3'b001);
  endtask

  task automatic t_victim;
    core_req(0, 32'h5014, 0, 11);
    expect_out(1, 32'h1010, 0, 1, a_line, "R6 evict M line with data first");
    expect_out(0, 32'h5010, 1, 0, 0, "R6 then upgrade request");
    send_up(1, 1, line_of(32'h5000), "R6 grant");
    wait_rsp(11, 32'h5001, "R6 load after eviction");
    core_req(0, 32'h9014, 0, 12);
    expect_out(1, 32'h5010, 0, 0, 0, "R6 evict S line without data");
    expect_out(0, 32'h9010, 1, 0, 0, "R6 upgrade after clean eviction");
    send_up(1, 1, line_of(32'h9000), "R6 grant 2");
    wait_rsp(12, 32'h9001, "R6 load after clean eviction");
  endtask

  task automatic t_dg_while_waiting;
    core_req(0, 32'h3034, 0, 13);
    expect_out(0, 32'h3030, 1, 0, 0, "R11 miss outstanding");
    downgrade(32'h9010, 0, 1, 0, 0, "R11 downgrade during wait");
    in_addr = 32'h3030;
    send_up(1, 1, line_of(32'h3000), "R11 late grant");
    wait_rsp(13, 32'h3001, "R11 pending load completes");
    core_req(0, 32'h9014, 0, 14);
    expect_out(0, 32'h9010, 1, 0, 0, "R11 line dropped to I, no eviction");
    send_up(1, 1, line_of(32'h9000), "R11 refill");
    wait_rsp(14, 32'h9001, "R11 refilled load");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_load_miss();
    t_load_hit();
    t_store_upgrade();
    t_downgrade_m();
    t_downgrade_ignored();
    t_priority();
    t_bad_op();
    t_victim();
    t_dg_while_waiting();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule